// File: doc/BRIEF.md
# Opcode Length and Cycle-Timing Sequencer

This block sits beside the fetch logic of a classic 8-bit accumulator processor. When a start strobe arrives with an opcode, it decodes the opcode into three things: the instruction length in bytes, the addressing-mode class, and whether the code is one of the 151 documented opcodes. It then counts off the instruction's cycles and marks the final one with a single-cycle `done` pulse. Operand fetch and execution are handled elsewhere.

The base cycle count depends on both the kind of operation and the addressing mode. Two flags are sampled together with the start strobe. `page_cross` adds a cycle to indexed reads. `branch_taken` adds one or two cycles to a conditional branch. Stores and read-modify-write forms always run their fixed count. While an instruction is running the block is busy, and any new start strobe is dropped.

Top module: `op_timing_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done`, `illegal` and `len` are 0 and `mode` is 0.
- R2: An accepted opcode sets `len` to 1 for implied, accumulator and undefined codes, to 2 for immediate, zero-page, zero-page indexed, both indirect-indexed forms and relative, and to 3 for absolute, absolute indexed and JMP indirect. `len`, `mode` and `illegal` hold until the next accepted start.
- R3: `mode` codes: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page,X, 5 zero page,Y, 6 absolute, 7 absolute,X, 8 absolute,Y, 9 (zp,X), 10 (zp),Y, 11 absolute indirect, 12 relative.
- R4: Base cycle counts:
  - ALU immediate 2, zero page 3, absolute 4, zero page,X 4, (zp,X) 6.
  - Read-modify-write: zero page 5, absolute and zero page,X 6, absolute,X 7. Accumulator shifts 2.
  - BRK 7, JSR 6, RTS 6, RTI 6, JMP absolute 3, JMP indirect 5.
  - Push 3, pull 4, transfers, flag operations and NOP 2.
- R5: A start seen while idle is accepted at that clock edge. From the next cycle, `busy` stays high for exactly the instruction's cycle count. `done` is high only on the last of those cycles.
- R6: For the variable-time reads ((zp),Y, absolute,X and absolute,Y loads/ALU, including LDX absolute,Y and LDY absolute,X), `page_cross`=1 adds exactly one cycle.
- R7: Stores (absolute indexed 5, (zp),Y 6), read-modify-write forms and fixed-time reads ignore `page_cross`.
- R8: A conditional branch takes 2 cycles when not taken, 3 when taken, and 4 when taken with `page_cross`=1.
- R9: A start arriving while `busy` is high, including on the `done` cycle, is ignored. The running count is not changed, and neither are `len`, `mode` or `illegal`.
- R10: Each of the 105 opcodes outside the documented set sets `illegal`=1, `len`=1 and `mode`=0, and completes in 2 cycles regardless of the two flags.
- R11: `page_cross` and `branch_taken` are used only in the cycle of the accepted start. Their values during `busy` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, qualifies `opcode` |
| opcode | input | 8 | Opcode to time |
| page_cross | input | 1 | Indexed address or branch target crosses a page |
| branch_taken | input | 1 | Conditional branch is taken |
| len | output | 2 | Instruction length in bytes |
| mode | output | 4 | Addressing-mode code (R3) |
| illegal | output | 1 | Opcode not in the documented set |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |

## Verification
Each operation family is run in each of its addressing modes with both flags clear. This separates the mode-dependent base counts, for example a zero-page read from a zero-page read-modify-write, or an indexed read from an indexed store. The variable-time reads and the stores sharing their modes are then rerun with `page_cross` set. Only the reads may lengthen. Branches are run under all three flag combinations. The flags are inverted while busy, which shows they are sampled only at the start. Extra strobes are placed mid-instruction and on the `done` cycle. A sweep over all 256 codes counts the undefined ones and confirms their 2-cycle timing.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [3:0] {
    AM_IMP  = 4'd0,
    AM_ACC  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_ABS  = 4'd6,
    AM_ABSX = 4'd7,
    AM_ABSY = 4'd8,
    AM_INDX = 4'd9,
    AM_INDY = 4'd10,
    AM_IND  = 4'd11,
    AM_REL  = 4'd12
  } amode_e;

  typedef enum logic [1:0] {
    PEN_NONE   = 2'd0,
    PEN_READ   = 2'd1,
    PEN_BRANCH = 2'd2
  } pen_e;

  localparam int unsigned CYC_W = 3;

  typedef struct packed {
    logic [1:0]       len;
    amode_e           mode;
    logic [CYC_W-1:0] base;
    pen_e             pen;
    logic             bad;
  } opinfo_t;

endpackage

// File: rtl/opseq_decode.sv
module opseq_decode
  import opseq_pkg::*;
(
  input  logic [7:0] opcode,
  output opinfo_t    info
);

  logic [2:0] grp_a;
  logic [2:0] grp_b;
  logic [1:0] grp_c;

  assign grp_a = opcode[7:5];
  assign grp_b = opcode[4:2];
  assign grp_c = opcode[1:0];

  function automatic opinfo_t mk(input logic [1:0] l, input amode_e m,
                                 input int unsigned b, input pen_e p);
    opinfo_t r;
    r.len  = l;
    r.mode = m;
    r.base = CYC_W'(b);
    r.pen  = p;
    r.bad  = 1'b0;
    return r;
  endfunction

  localparam opinfo_t BAD = '{len: 2'd1, mode: AM_IMP, base: CYC_W'(2),
                              pen: PEN_NONE, bad: 1'b1};

  logic is_st;
  logic is_rmw;
  logic is_xreg;

  always_comb begin
    is_st   = (grp_a == 3'b100);
    is_rmw  = !grp_a[2] || (grp_a[2:1] == 2'b11);
    is_xreg = (grp_a[2:1] == 2'b10);
    info    = BAD;
    unique case (grp_c)
      2'b01: begin
        unique case (grp_b)
          3'b000: info = mk(2'd2, AM_INDX, 6, PEN_NONE);
          3'b001: info = mk(2'd2, AM_ZP, 3, PEN_NONE);
          3'b010: info = is_st ? BAD : mk(2'd2, AM_IMM, 2, PEN_NONE);
          3'b011: info = mk(2'd3, AM_ABS, 4, PEN_NONE);
          3'b100: info = is_st ? mk(2'd2, AM_INDY, 6, PEN_NONE)
                               : mk(2'd2, AM_INDY, 5, PEN_READ);
          3'b101: info = mk(2'd2, AM_ZPX, 4, PEN_NONE);
          3'b110: info = is_st ? mk(2'd3, AM_ABSY, 5, PEN_NONE)
                               : mk(2'd3, AM_ABSY, 4, PEN_READ);
          default: info = is_st ? mk(2'd3, AM_ABSX, 5, PEN_NONE)
                                : mk(2'd3, AM_ABSX, 4, PEN_READ);
        endcase
      end
      2'b10: begin
        unique case (grp_b)
          3'b000: info = (grp_a == 3'b101) ? mk(2'd2, AM_IMM, 2, PEN_NONE) : BAD;
          3'b001: info = mk(2'd2, AM_ZP, is_rmw ? 5 : 3, PEN_NONE);
          3'b010: info = mk(2'd1, grp_a[2] ? AM_IMP : AM_ACC, 2, PEN_NONE);
          3'b011: info = mk(2'd3, AM_ABS, is_rmw ? 6 : 4, PEN_NONE);
          3'b100: info = BAD;
          3'b101: info = mk(2'd2, is_xreg ? AM_ZPY : AM_ZPX, is_rmw ? 6 : 4, PEN_NONE);
          3'b110: info = is_xreg ? mk(2'd1, AM_IMP, 2, PEN_NONE) : BAD;
          default: begin
            if (is_st)                  info = BAD;
            else if (grp_a == 3'b101)   info = mk(2'd3, AM_ABSY, 4, PEN_READ);
            else                        info = mk(2'd3, AM_ABSX, 7, PEN_NONE);
          end
        endcase
      end
      2'b00: begin
        unique case (grp_b)
          3'b000: begin
            unique case (grp_a)
              3'd0:    info = mk(2'd1, AM_IMP, 7, PEN_NONE);
              3'd1:    info = mk(2'd3, AM_ABS, 6, PEN_NONE);
              3'd2,
              3'd3:    info = mk(2'd1, AM_IMP, 6, PEN_NONE);
              3'd4:    info = BAD;
              default: info = mk(2'd2, AM_IMM, 2, PEN_NONE);
            endcase
          end
          3'b001: info = (grp_a == 3'd1 || grp_a[2]) ? mk(2'd2, AM_ZP, 3, PEN_NONE) : BAD;
          3'b010: info = mk(2'd1, AM_IMP, grp_a[2] ? 2 : (grp_a[0] ? 4 : 3), PEN_NONE);
          3'b011: begin
            unique case (grp_a)
              3'd0:    info = BAD;
              3'd2:    info = mk(2'd3, AM_ABS, 3, PEN_NONE);
              3'd3:    info = mk(2'd3, AM_IND, 5, PEN_NONE);
              default: info = mk(2'd3, AM_ABS, 4, PEN_NONE);
            endcase
          end
          3'b100: info = mk(2'd2, AM_REL, 2, PEN_BRANCH);
          3'b101: info = is_xreg ? mk(2'd2, AM_ZPX, 4, PEN_NONE) : BAD;
          3'b110: info = mk(2'd1, AM_IMP, 2, PEN_NONE);
          default: info = (grp_a == 3'd5) ? mk(2'd3, AM_ABSX, 4, PEN_READ) : BAD;
        endcase
      end
      default: info = BAD;
    endcase
  end

  // R10: an undefined code must look like a one-byte, two-cycle implied op
  always_comb begin
    if (info.bad) begin
      a_bad_shape_r10: assert (info.len == 2'd1 && info.base == CYC_W'(2)
                               && info.pen == PEN_NONE);
    end
  end

endmodule

// File: rtl/opseq_penalty.sv
module opseq_penalty
  import opseq_pkg::*;
(
  input  logic [CYC_W-1:0] base,
  input  pen_e             pen,
  input  logic             page_cross,
  input  logic             branch_taken,
  output logic [CYC_W-1:0] total
);

  always_comb begin
    unique case (pen)
      PEN_READ:   total = base + CYC_W'(page_cross);
      PEN_BRANCH: total = base + CYC_W'(branch_taken)
                               + CYC_W'(branch_taken & page_cross);
      default:    total = base;
    endcase
  end

endmodule

// File: rtl/opseq_counter.sv
module opseq_counter #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] total,
  output logic          accept,
  output logic          busy,
  output logic          done
);

  logic          busy_q, busy_d;
  logic [CW-1:0] rem_q, rem_d;

  assign accept = start && !busy_q;
  assign busy   = busy_q;
  assign done   = busy_q && (rem_q == '0);

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    if (accept) begin
      busy_d = 1'b1;
      rem_d  = total - CW'(1);
    end else if (busy_q) begin
      if (rem_q == '0) busy_d = 1'b0;
      else             rem_d  = rem_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
    end
  end

  p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_no_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/op_timing_seq.sv
module op_timing_seq
  import opseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       page_cross,
  input  logic       branch_taken,
  output logic [1:0] len,
  output logic [3:0] mode,
  output logic       illegal,
  output logic       busy,
  output logic       done
);

  opinfo_t          dec;
  logic [CYC_W-1:0] total;
  logic             accept;

  logic [1:0] len_q;
  amode_e     mode_q;
  logic       bad_q;

  opseq_decode u_dec (
    .opcode (opcode),
    .info   (dec)
  );

  opseq_penalty u_pen (
    .base         (dec.base),
    .pen          (dec.pen),
    .page_cross   (page_cross),
    .branch_taken (branch_taken),
    .total        (total)
  );

  opseq_counter #(.CW(CYC_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .total  (total),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= 2'd0;
      mode_q <= AM_IMP;
      bad_q  <= 1'b0;
    end else if (accept) begin
      len_q  <= dec.len;
      mode_q <= dec.mode;
      bad_q  <= dec.bad;
    end
  end

  assign len     = len_q;
  assign mode    = mode_q;
  assign illegal = bad_q;

  p_info_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(len) && $stable(mode) && $stable(illegal)));
  p_bad_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (len == 2'd1 && mode == 4'd0));

endmodule

// File: tb/tb_op_timing_seq.sv
`timescale 1ns/1ps
module tb_op_timing_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] opcode;
  logic       page_cross;
  logic       branch_taken;
  logic [1:0] len;
  logic [3:0] mode;
  logic       illegal;
  logic       busy;
  logic       done;

  int total_chk = 0;
  int bad_chk   = 0;

  // reference model state
  bit m_on   = 1'b0;
  bit m_busy = 1'b0;
  int m_rem  = 0;
  int m_next = 0;

  always #4 clk = ~clk;

  op_timing_seq dut (
    .clk (clk), .rst_n (rst_n), .start (start), .opcode (opcode),
    .page_cross (page_cross), .branch_taken (branch_taken),
    .len (len), .mode (mode), .illegal (illegal), .busy (busy), .done (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      m_rem  = 0;
    end else if (m_busy) begin
      if (m_rem == 1) m_busy = 1'b0;
      else            m_rem  = m_rem - 1;
    end else if (start) begin
      m_busy = 1'b1;
      m_rem  = m_next;
    end
  end

  // per-cycle comparison of busy/done with the model (R5)
  always @(negedge clk) begin
    if (rst_n && m_on) begin
      chk(busy == m_busy, "R5 busy", busy, m_busy);
      chk(done == (m_busy && m_rem == 1), "R5 done", done, m_busy && m_rem == 1);
    end
  end

  task automatic run_op(input logic [7:0] op, input int elen, input int emode,
                        input int ecyc, input bit pc, input bit bt, input bit eill,
                        input string tag);
    int n;
    @(negedge clk);
    opcode = op; start = 1'b1; page_cross = pc; branch_taken = bt; m_next = ecyc;
    @(negedge clk);
    start = 1'b0;
    page_cross = ~pc;       // R11: flags flipped while busy must not matter
    branch_taken = ~bt;
    chk(len == 2'(elen), {tag, " R2 len"}, len, elen);
    chk(mode == 4'(emode), {tag, " R3 mode"}, mode, emode);
    chk(illegal == eill, {tag, " R10 illegal"}, illegal, eill);
    n = 0;
    while (busy && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == ecyc, {tag, " R11 cycles"}, n, ecyc);
    page_cross = 1'b0; branch_taken = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad_chk++;
    total_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    int nill;
    int n;
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; page_cross = 1'b0; branch_taken = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !illegal && len == 0 && mode == 0, "R1 reset", {busy, done, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !illegal && len == 0 && mode == 0, "R1 after release", {busy, done, illegal}, 0);
    m_on = 1'b1;

    // R4 base counts
    run_op(8'h69, 2, 2, 2, 0, 0, 0, "R4 adc imm");
    run_op(8'h65, 2, 3, 3, 0, 0, 0, "R4 adc zp");
    run_op(8'h6D, 3, 6, 4, 0, 0, 0, "R4 adc abs");
    run_op(8'h61, 2, 9, 6, 0, 0, 0, "R4 adc indx");
    run_op(8'h75, 2, 4, 4, 0, 0, 0, "R4 adc zpx");
    run_op(8'hE6, 2, 3, 5, 0, 0, 0, "R4 inc zp");
    run_op(8'hEE, 3, 6, 6, 0, 0, 0, "R4 inc abs");
    run_op(8'hF6, 2, 4, 6, 0, 0, 0, "R4 inc zpx");
    run_op(8'hFE, 3, 7, 7, 0, 0, 0, "R4 inc absx");
    run_op(8'h4A, 1, 1, 2, 0, 0, 0, "R4 lsr acc");
    run_op(8'h00, 1, 0, 7, 0, 0, 0, "R4 brk");
    run_op(8'h20, 3, 6, 6, 0, 0, 0, "R4 jsr");
    run_op(8'h4C, 3, 6, 3, 0, 0, 0, "R4 jmp abs");
    run_op(8'h6C, 3, 11, 5, 0, 0, 0, "R4 jmp ind");
    run_op(8'h60, 1, 0, 6, 0, 0, 0, "R4 rts");
    run_op(8'h40, 1, 0, 6, 0, 0, 0, "R4 rti");
    run_op(8'h48, 1, 0, 3, 0, 0, 0, "R4 pha");
    run_op(8'h68, 1, 0, 4, 0, 0, 0, "R4 pla");
    run_op(8'h08, 1, 0, 3, 0, 0, 0, "R4 php");
    run_op(8'h28, 1, 0, 4, 0, 0, 0, "R4 plp");
    run_op(8'hAA, 1, 0, 2, 0, 0, 0, "R4 tax");
    run_op(8'h18, 1, 0, 2, 0, 0, 0, "R4 clc");
    run_op(8'hEA, 1, 0, 2, 0, 0, 0, "R4 nop");
    run_op(8'h9A, 1, 0, 2, 0, 0, 0, "R4 txs");
    run_op(8'hB6, 2, 5, 4, 0, 0, 0, "R4 ldx zpy");
    run_op(8'hA2, 2, 2, 2, 0, 0, 0, "R4 ldx imm");

    // R6 variable-time reads
    run_op(8'h71, 2, 10, 5, 0, 0, 0, "R6 adc indy no cross");
    run_op(8'h71, 2, 10, 6, 1, 0, 0, "R6 adc indy cross");
    run_op(8'h7D, 3, 7, 5, 1, 0, 0, "R6 adc absx cross");
    run_op(8'h79, 3, 8, 4, 0, 0, 0, "R6 adc absy no cross");
    run_op(8'h79, 3, 8, 5, 1, 0, 0, "R6 adc absy cross");
    run_op(8'hBE, 3, 8, 5, 1, 0, 0, "R6 ldx absy cross");
    run_op(8'hBC, 3, 7, 5, 1, 0, 0, "R6 ldy absx cross");

    // R7 page_cross ignored
    run_op(8'h91, 2, 10, 6, 1, 0, 0, "R7 sta indy");
    run_op(8'h9D, 3, 7, 5, 1, 0, 0, "R7 sta absx");
    run_op(8'h99, 3, 8, 5, 1, 0, 0, "R7 sta absy");
    run_op(8'hFE, 3, 7, 7, 1, 0, 0, "R7 inc absx");
    run_op(8'h8D, 3, 6, 4, 1, 0, 0, "R7 sta abs");
    run_op(8'h61, 2, 9, 6, 1, 1, 0, "R7 adc indx");

    // R8 branches
    run_op(8'hF0, 2, 12, 2, 0, 0, 0, "R8 beq not taken");
    run_op(8'hF0, 2, 12, 2, 1, 0, 0, "R8 beq not taken cross");
    run_op(8'hD0, 2, 12, 3, 0, 1, 0, "R8 bne taken");
    run_op(8'h10, 2, 12, 4, 1, 1, 0, "R8 bpl taken cross");
    run_op(8'h90, 2, 12, 3, 0, 1, 0, "R8 bcc taken");

    // R10 undefined codes
    run_op(8'h02, 1, 0, 2, 1, 1, 1, "R10 code 02");
    run_op(8'h89, 1, 0, 2, 0, 0, 1, "R10 code 89");
    run_op(8'hFF, 1, 0, 2, 1, 0, 1, "R10 code FF");

    // R9 start while busy
    @(negedge clk);
    opcode = 8'h00; start = 1'b1; m_next = 7;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      if (n == 3) begin opcode = 8'hA9; start = 1'b1; end
      else start = 1'b0;
      n++;
      @(negedge clk);
    end
    opcode = 8'hA9; start = 1'b1;   // strobe on the done cycle
    chk(n == 7, "R9 count kept", n, 7);
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R9 done-cycle strobe ignored", busy, 0);
    chk(len == 2'd1 && mode == 4'd0, "R9 info kept", len, 1);

    // R10 sweep
    m_on = 1'b0;
    nill = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      opcode = 8'(k); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (illegal) begin
        nill++;
        n = 0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        chk(n == 2 && len == 2'd1 && mode == 4'd0, "R10 undefined timing", n, 2);
      end else begin
        while (busy) @(negedge clk);
      end
    end
    chk(nill == 105, "R10 undefined count", nill, 105);

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule